// File: doc/BRIEF.md
# Ring Oscillation Measurement Window Controller

This block is the central timekeeper for an interconnect test that closes wires and wrapper paths into free-running rings. A start request opens a measurement window: a global oscillation enable goes high, the controller counts system clock cycles, and after a programmed number of cycles it drops the enable again. Dropping the enable freezes the ring counters spread across the chip, so each of them holds the number of ring transitions seen during a window of known length. Since the window length is a known number of system clock cycles, a ring count divided by that length, times the system clock frequency, estimates the ring frequency.

Once the window has closed, ring counts are read back one at a time and offered to the controller together with a valid strobe. Each one is judged against an inclusive band of acceptable counts, derived from the slowest and fastest legal ring frequency multiplied by the window length. A count outside the band points to a delay fault, and a count of zero points to a ring that never oscillated because a wire is stuck or open.

Top module: `osc_window_timer`

## Requirements
- R1: After reset, the enable, busy, done, verdict-valid and pass outputs are all 0.
- R2: A start request sampled at a clock edge while the controller is not busy, with a nonzero reference count, sets both the enable and busy to 1 from the next cycle.
- R3: Once opened, the enable stays at 1 for exactly as many clock cycles as the reference count, then returns to 0. Busy equals the enable.
- R4: Done is 1 for exactly one cycle: the first cycle in which the enable is 0 again after a window.
- R5: A start request while busy is ignored. The running window keeps its length and does not restart.
- R6: A start request with a reference count of 0 is ignored. Enable and busy stay at 0, and done stays at 0.
- R7: The reference count is captured when the window opens. Later changes to the reference count input do not change the window length.
- R8: A ring count offered with its valid strobe while not busy gives, in the next cycle, a one-cycle verdict-valid pulse. In that same cycle pass is 1 exactly when low bound ≤ count ≤ high bound, where both bounds are inclusive.
- R9: A ring count of 0 always yields pass = 0, even when the low bound is 0.
- R10: A valid strobe while busy is ignored. No verdict-valid pulse follows, and pass keeps its previous value. Pass also holds its value between verdicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the time base of the window |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to open a measurement window |
| ref_count_i | input | CNT_W | Window length in system clock cycles |
| band_lo_i | input | RING_W | Smallest acceptable ring count (inclusive) |
| band_hi_i | input | RING_W | Largest acceptable ring count (inclusive) |
| ring_count_i | input | RING_W | Ring count read back after the window |
| ring_valid_i | input | 1 | Strobe marking ring_count_i as valid |
| osc_en_o | output | 1 | Global oscillation enable |
| busy_o | output | 1 | A window is open |
| done_o | output | 1 | One-cycle pulse as the window closes |
| verdict_valid_o | output | 1 | One-cycle pulse when pass_o is fresh |
| pass_o | output | 1 | Verdict for the last accepted ring count |

## Verification
The hardest situations to reach are requests that arrive at awkward moments. These are a second start request partway through an open window, a change of the reference count right after the window opens, and a ring count strobed while the window is still open. None of these changes any output in the cycle it arrives, so the stimulus has to measure the whole window length in clock cycles. It also has to set up a known earlier verdict, so that a missing verdict-valid pulse and an unchanged pass value can both be seen. Band edges are covered by a table of counts placed exactly at, one below and one above each bound, plus zero and full-scale counts.

// File: rtl/osc_timer_pkg.sv
package osc_timer_pkg;

  // True when the counter, after this cycle's increment, reaches the limit.
  function automatic logic reaches_limit(longint unsigned elapsed,
                                         longint unsigned limit);
    return (elapsed + 64'd1) == limit;
  endfunction

  // Band check; a silent ring (count zero) never passes.
  function automatic logic count_in_band(longint unsigned count,
                                         longint unsigned lo,
                                         longint unsigned hi);
    return (count != 64'd0) && (count >= lo) && (count <= hi);
  endfunction

endpackage

// File: rtl/osc_win_ctr.sv
module osc_win_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [CNT_W-1:0] ref_cnt,
  output logic             en_o,
  output logic             done_o,
  output logic             start_accept_o,
  output logic             window_last_o
);
  localparam int PAD_W = 64 - CNT_W;

  logic [CNT_W-1:0] elapsed_q;
  logic [CNT_W-1:0] limit_q;
  logic             en_q;
  logic             done_q;

  assign start_accept_o = start_req & ~en_q & (ref_cnt != '0);
  assign window_last_o  = en_q &
    osc_timer_pkg::reaches_limit({{PAD_W{1'b0}}, elapsed_q},
                                 {{PAD_W{1'b0}}, limit_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      done_q    <= 1'b0;
      elapsed_q <= '0;
      limit_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_accept_o) begin
        en_q      <= 1'b1;
        elapsed_q <= '0;
        limit_q   <= ref_cnt;
      end else if (en_q) begin
        elapsed_q <= elapsed_q + 1'b1;
        if (window_last_o) begin
          en_q   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign en_o   = en_q;
  assign done_o = done_q;
endmodule

// File: rtl/osc_band_judge.sv
module osc_band_judge #(
  parameter int RING_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [RING_W-1:0] count,
  input  logic [RING_W-1:0] lo,
  input  logic [RING_W-1:0] hi,
  output logic              verdict_valid_o,
  output logic              pass_o
);
  localparam int PAD_W = 64 - RING_W;

  logic in_band;
  logic vv_q;
  logic pass_q;

  assign in_band = osc_timer_pkg::count_in_band({{PAD_W{1'b0}}, count},
                                                {{PAD_W{1'b0}}, lo},
                                                {{PAD_W{1'b0}}, hi});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vv_q   <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      vv_q <= take;
      if (take) pass_q <= in_band;
    end
  end

  assign verdict_valid_o = vv_q;
  assign pass_o          = pass_q;
endmodule

// File: rtl/osc_window_timer.sv
module osc_window_timer #(
  parameter int CNT_W  = 16,
  parameter int RING_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  ref_count_i,
  input  logic [RING_W-1:0] band_lo_i,
  input  logic [RING_W-1:0] band_hi_i,
  input  logic [RING_W-1:0] ring_count_i,
  input  logic              ring_valid_i,
  output logic              osc_en_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              verdict_valid_o,
  output logic              pass_o
);
  logic start_accept;
  logic window_last;
  logic ring_take;
  logic en_w;

  osc_win_ctr #(.CNT_W(CNT_W)) u_win (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_req      (start_i),
    .ref_cnt        (ref_count_i),
    .en_o           (en_w),
    .done_o         (done_o),
    .start_accept_o (start_accept),
    .window_last_o  (window_last)
  );

  // Counts are only judged once the window has closed.
  assign ring_take = ring_valid_i & ~en_w;

  osc_band_judge #(.RING_W(RING_W)) u_judge (
    .clk             (clk),
    .rst_n           (rst_n),
    .take            (ring_take),
    .count           (ring_count_i),
    .lo              (band_lo_i),
    .hi              (band_hi_i),
    .verdict_valid_o (verdict_valid_o),
    .pass_o          (pass_o)
  );

  assign osc_en_o = en_w;
  assign busy_o   = en_w;
endmodule

// File: rtl/osc_window_timer_chk.sv
module osc_window_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int RING_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [CNT_W-1:0]  ref_count_i,
  input logic [RING_W-1:0] ring_count_i,
  input logic              ring_valid_i,
  input logic              osc_en_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              verdict_valid_o,
  input logic              pass_o,
  input logic              start_accept,
  input logic              window_last
);
  logic [CNT_W:0] seen_q;
  logic [CNT_W:0] want_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      want_q <= '0;
    end else if (start_accept) begin
      seen_q <= '0;
      want_q <= {1'b0, ref_count_i};
    end else if (osc_en_o) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  // R2 / R5 / R6: the window opens only on an accepted request
  p_open_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en_o) |-> $past(start_i) && !$past(busy_o) && ($past(ref_count_i) != '0));

  // R3: enabled cycles equal the captured reference count
  p_window_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en_o) |-> (seen_q == want_q));

  // R4: done marks the fall of the enable and lasts one cycle
  p_done_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en_o) |-> done_o);
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5: an open window runs on until its last cycle
  p_no_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en_o && !window_last |=> osc_en_o);

  // R8: verdict one cycle after an accepted strobe
  p_verdict_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ring_valid_i && !busy_o |=> verdict_valid_o);

  // R9: a zero count never passes
  p_zero_fails_r9: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid_o && ($past(ring_count_i) == '0) |-> !pass_o);

  // R10: pass only moves with a verdict
  p_pass_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_valid_o |-> $stable(pass_o));
endmodule

bind osc_window_timer osc_window_timer_chk #(.CNT_W(CNT_W), .RING_W(RING_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .start_i         (start_i),
  .ref_count_i     (ref_count_i),
  .ring_count_i    (ring_count_i),
  .ring_valid_i    (ring_valid_i),
  .osc_en_o        (osc_en_o),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .verdict_valid_o (verdict_valid_o),
  .pass_o          (pass_o),
  .start_accept    (start_accept),
  .window_last     (window_last)
);

// File: tb/osc_window_timer_bench.sv
module osc_window_timer_bench;
  localparam int CNT_W  = 16;
  localparam int RING_W = 16;
  localparam int NVEC   = 8;

  // {count, low bound, high bound}
  localparam logic [47:0] VEC [NVEC] = '{
    {16'd100,   16'd90, 16'd110},
    {16'd90,    16'd90, 16'd110},
    {16'd110,   16'd90, 16'd110},
    {16'd89,    16'd90, 16'd110},
    {16'd111,   16'd90, 16'd110},
    {16'd0,     16'd0,  16'd50},
    {16'd1,     16'd0,  16'd50},
    {16'hFFFF,  16'd1,  16'hFFFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [CNT_W-1:0]  ref_count_i = '0;
  logic [RING_W-1:0] band_lo_i = '0;
  logic [RING_W-1:0] band_hi_i = '0;
  logic [RING_W-1:0] ring_count_i = '0;
  logic ring_valid_i = 1'b0;
  logic osc_en_o, busy_o, done_o, verdict_valid_o, pass_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5ns clk = ~clk;

  osc_window_timer #(.CNT_W(CNT_W), .RING_W(RING_W)) u_osc_window_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ref_count_i(ref_count_i),
    .band_lo_i(band_lo_i), .band_hi_i(band_hi_i), .ring_count_i(ring_count_i),
    .ring_valid_i(ring_valid_i), .osc_en_o(osc_en_o), .busy_o(busy_o),
    .done_o(done_o), .verdict_valid_o(verdict_valid_o), .pass_o(pass_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected verdict restated from the band rule.
  function automatic bit want_pass(int c, int lo, int hi);
    if (c == 0) return 0;
    return !(c < lo) && !(c > hi);
  endfunction

  // Count enabled cycles starting at the current negedge; return at the first low one.
  task automatic count_window(output int len, input int poke_at, input int poke_ref);
    len = 0;
    while (osc_en_o === 1'b1 && len < 100000) begin
      len++;
      start_i = (len == poke_at);
      if (len == poke_at) ref_count_i = poke_ref[CNT_W-1:0];
      @(negedge clk);
    end
    start_i = 1'b0;
  endtask

  task automatic open_window(input int n);
    @(negedge clk);
    ref_count_i = n[CNT_W-1:0];
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic judge(input int c, input int lo, input int hi);
    @(negedge clk);
    ring_count_i = c[RING_W-1:0];
    band_lo_i = lo[RING_W-1:0];
    band_hi_i = hi[RING_W-1:0];
    ring_valid_i = 1'b1;
    @(negedge clk);
    ring_valid_i = 1'b0;
  endtask

  initial begin
    #(200000 * 5ns);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int len;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 en", osc_en_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 vvalid", verdict_valid_o, 0);
    chk("R1 pass", pass_o, 0);
    rst_n = 1'b1;

    // R8 / R9 band table
    for (int i = 0; i < NVEC; i++) begin
      int c, lo, hi;
      c  = int'(VEC[i][47:32]);
      lo = int'(VEC[i][31:16]);
      hi = int'(VEC[i][15:0]);
      judge(c, lo, hi);
      chk("R8 vvalid", verdict_valid_o, 1);
      chk((c == 0) ? "R9 zero count" : "R8 pass", pass_o, want_pass(c, lo, hi));
      @(negedge clk);
      chk("R8 vvalid pulse", verdict_valid_o, 0);
    end

    // R2 / R3 / R4 plain window
    open_window(5);
    chk("R2 en", osc_en_o, 1);
    chk("R2 busy", busy_o, 1);
    count_window(len, 0, 0);
    chk("R3 length 5", len, 5);
    chk("R4 done", done_o, 1);
    chk("R3 busy low", busy_o, 0);
    @(negedge clk);
    chk("R4 done pulse", done_o, 0);

    // R3 shortest window
    open_window(1);
    count_window(len, 0, 0);
    chk("R3 length 1", len, 1);
    chk("R4 done n1", done_o, 1);

    // R6 zero reference count
    open_window(0);
    chk("R6 en", osc_en_o, 0);
    @(negedge clk);
    chk("R6 done", done_o, 0);

    // R5 start while busy
    open_window(6);
    count_window(len, 2, 20);
    chk("R5 length", len, 6);
    @(negedge clk);
    chk("R5 no restart", osc_en_o, 0);

    // R7 reference changed after opening
    open_window(4);
    ref_count_i = 16'd30;
    count_window(len, 0, 0);
    chk("R7 length", len, 4);

    // R10 strobe during an open window (pass currently 1 from a fresh verdict)
    judge(100, 90, 110);
    chk("R10 setup pass", pass_o, 1);
    open_window(10);
    ring_count_i = '0;
    ring_valid_i = 1'b1;
    @(negedge clk);
    ring_valid_i = 1'b0;
    chk("R10 no vvalid", verdict_valid_o, 0);
    chk("R10 pass held", pass_o, 1);
    count_window(len, 0, 0);
    chk("R10 window intact", len, 9);

    // R1 reset in the middle of a window
    open_window(50);
    rst_n = 1'b0;
    #1ns;
    chk("R1 en async", osc_en_o, 0);
    chk("R1 pass async", pass_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after", busy_o, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule